// File: doc/BRIEF.md
# Core clock source switcher

This block picks the clock that drives a processor core and its cache. Two clocks arrive: a bus clock and a faster core clock. A two-bit mode field, taken from the processor's control register, sets how they are used. In bus-clock mode the bus clock drives the core and the fast clock input is ignored. In asynchronous mode the core runs on the fast clock. For each external access it moves to the bus clock, and it moves back to the fast clock when the access ends.

The access logic raises a one-cycle request on the bus clock. It waits until the status output reports that the bus clock is driving the core, performs the access, and then pulses a done indication. The handover uses glitch-free switching. Each source has an enable that passes through a chain of flops clocked on that source's falling edge. A source is enabled only after the other source's enable has been seen low, so the output never carries a shortened pulse. Either input clock may stop. The output then holds its level.

Top module: `core_clk_switch`

## Requirements
- R1: The mode field is sampled on the bus clock. Value 00 selects bus-clock mode, and both 11 and 10 select asynchronous mode. During and after reset the bus clock is the selected source: `bus_on`=1 and `mode_err`=0 under mode 00.
- R2: Mode value 01 (the unsupported synchronous mode) sets `mode_err` to 1 within 3 bus-clock cycles. The block then behaves as bus-clock mode: `bus_on`=1 and `core_clk` follows `bclk`.
- R3: In bus-clock mode `core_clk` follows `bclk`, and stopping `fclk` has no effect on it.
- R4: In asynchronous mode with no access pending, `core_clk` follows `fclk` and `bus_on`=0.
- R5: Every high and low phase of `core_clk` lasts at least one half period of the faster clock, including across every source change. The two source enables are never both high.
- R6: In asynchronous mode, a one-cycle `acc_req` makes `bus_on` rise within 5 bus-clock cycles. While the access lasts, `core_clk` follows `bclk` and `bus_on` stays 1 until `acc_done`.
- R7: After a one-cycle `acc_done`, within 4 bus-clock cycles `bus_on` returns to 0 and `core_clk` follows `fclk` again.
- R8: When the selected source clock stops, `core_clk` holds a constant level.
- R9: `acc_done` with no access in progress is ignored: the core stays on `fclk` and `bus_on` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock; the control logic runs on its rising edge |
| fclk | input | 1 | Fast core clock, higher in frequency than `bclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Clocking mode field from the control register |
| acc_req | input | 1 | One-cycle external access request (bus clock) |
| acc_done | input | 1 | One-cycle external access completion (bus clock) |
| core_clk | output | 1 | Clock for the core and cache |
| bus_on | output | 1 | High while the bus clock drives the core |
| mode_err | output | 1 | High while the unsupported synchronous mode is set |

## Verification
A stuck access state shows up within a few bus cycles. Either `bus_on` never rises after a request, or it stays high after `acc_done`, and in both cases the edge counts of `core_clk` match the wrong source. A broken enable chain or broken cross-feedback shows up as a short pulse on `core_clk`. A width monitor catches that at the first switch. A wrong mode decode shows up in `mode_err` or in the selected source within three bus cycles of the mode change.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  // Mode field values; 10 is folded into asynchronous operation
  typedef enum logic [1:0] {
    MODE_BUS   = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_ALT   = 2'b10,
    MODE_ASYNC = 2'b11
  } clk_mode_e;

  // External access handshake state
  typedef enum logic [1:0] {
    ACC_IDLE = 2'b00,
    ACC_WAIT = 2'b01,
    ACC_BUSY = 2'b10
  } acc_state_e;

endpackage

// File: rtl/clksw_rst_sync.sv
`timescale 1ns/1ps
module clksw_rst_sync #(
  parameter int STAGES = 2,
  parameter bit FALL   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  generate
    if (FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_mode_dec.sv
`timescale 1ns/1ps
module clksw_mode_dec
  import clksw_pkg::*;
(
  input  clk_mode_e mode_i,
  output logic      use_async_o,
  output logic      illegal_o
);

  always_comb begin
    use_async_o = 1'b0;
    illegal_o   = 1'b0;
    unique case (mode_i)
      MODE_BUS:   use_async_o = 1'b0;
      MODE_SYNC:  illegal_o   = 1'b1;   // R2: fall back to bus clock
      MODE_ALT:   use_async_o = 1'b1;
      MODE_ASYNC: use_async_o = 1'b1;
      default:    use_async_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/clksw_acc_ctrl.sv
`timescale 1ns/1ps
module clksw_acc_ctrl
  import clksw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  clk_mode_e mode_i,
  input  logic      acc_req_i,
  input  logic      acc_done_i,
  input  logic      bus_on_i,
  output logic      sel_bus_o,
  output logic      mode_err_o
);

  clk_mode_e  mode_q, mode_d;
  acc_state_e state_q, state_d;
  logic       use_async;
  logic       illegal;

  clksw_mode_dec u_dec (
    .mode_i      (mode_q),
    .use_async_o (use_async),
    .illegal_o   (illegal)
  );

  // next-state
  always_comb begin
    mode_d  = mode_i;
    state_d = state_q;
    unique case (state_q)
      ACC_IDLE: if (acc_req_i)  state_d = ACC_WAIT;
      ACC_WAIT: if (bus_on_i)   state_d = ACC_BUSY;
      ACC_BUSY: if (acc_done_i) state_d = ACC_IDLE;
      default:                  state_d = ACC_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_BUS;
      state_q <= ACC_IDLE;
    end else begin
      mode_q  <= mode_d;
      state_q <= state_d;
    end
  end

  assign sel_bus_o  = !use_async || (state_q != ACC_IDLE);
  assign mode_err_o = illegal;

  a_r2_sync_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> sel_bus_o);

  a_r6_busy_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ACC_BUSY) |-> bus_on_i);

  a_r6_wait_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ACC_WAIT && bus_on_i) |=> (state_q == ACC_BUSY));

  a_r9_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ACC_IDLE && !acc_req_i) |=> (state_q == ACC_IDLE));

endmodule

// File: rtl/clksw_src_gate.sv
`timescale 1ns/1ps
module clksw_src_gate #(
  parameter int STAGES   = 2,
  parameter bit RESET_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic other_en_i,
  output logic en_o
);

  localparam logic [STAGES-1:0] RST_VAL = {STAGES{RESET_ON}};

  logic              rst_loc_n;
  logic [STAGES-1:0] en_q;
  logic [STAGES-1:0] en_d;

  clksw_rst_sync #(.STAGES(2), .FALL(1'b1)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_loc_n)
  );

  // enable requested only once the other source is seen off
  always_comb begin
    en_d = {en_q[STAGES-2:0], want_i && !other_en_i};
  end

  always_ff @(negedge clk or negedge rst_loc_n) begin
    if (!rst_loc_n) en_q <= RST_VAL;
    else            en_q <= en_d;
  end

  assign en_o = en_q[STAGES-1];

  a_r5_rise_after_request: assert property (@(negedge clk) disable iff (!rst_loc_n)
    $rose(en_o) |-> $past(want_i, STAGES));

endmodule

// File: rtl/core_clk_switch.sv
`timescale 1ns/1ps
module core_clk_switch
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       bclk,
  input  logic       fclk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       acc_req,
  input  logic       acc_done,
  output logic       core_clk,
  output logic       bus_on,
  output logic       mode_err
);

  localparam int NSRC = 2;   // index 0: bus clock, index 1: fast clock

  logic            ctrl_rst_n;
  logic            sel_bus;
  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] src_want;
  logic [NSRC-1:0] src_en;

  clksw_rst_sync #(.STAGES(2), .FALL(1'b0)) u_rst_ctrl (
    .clk        (bclk),
    .rst_n      (rst_n),
    .rst_sync_n (ctrl_rst_n)
  );

  clksw_acc_ctrl u_ctrl (
    .clk        (bclk),
    .rst_n      (ctrl_rst_n),
    .mode_i     (clk_mode_e'(mode)),
    .acc_req_i  (acc_req),
    .acc_done_i (acc_done),
    .bus_on_i   (bus_on),
    .sel_bus_o  (sel_bus),
    .mode_err_o (mode_err)
  );

  assign src_clk  = {fclk, bclk};
  assign src_want = {!sel_bus, sel_bus};

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      clksw_src_gate #(
        .STAGES   (SYNC_STAGES),
        .RESET_ON (gi == 0)
      ) u_gate (
        .clk        (src_clk[gi]),
        .rst_n      (rst_n),
        .want_i     (src_want[gi]),
        .other_en_i (src_en[NSRC-1-gi]),
        .en_o       (src_en[gi])
      );
    end
  endgenerate

  // enables change only while their own source is low
  assign core_clk = |(src_clk & src_en);
  assign bus_on   = src_en[0];

  a_r5_excl_bus: assert property (@(posedge bclk) disable iff (!rst_n)
    !(src_en[0] && src_en[1]));

  a_r5_excl_fast: assert property (@(posedge fclk) disable iff (!rst_n)
    !(src_en[0] && src_en[1]));

endmodule

// File: tb/core_clk_switch_bench.sv
`timescale 1ns/1ps
module core_clk_switch_bench;

  logic       bclk = 1'b0;
  logic       fclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       acc_req = 1'b0;
  logic       acc_done = 1'b0;
  logic       core_clk;
  logic       bus_on;
  logic       mode_err;

  logic b_run = 1'b1;
  logic f_run = 1'b1;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // 200 MHz fast clock, slower bus clock
  always begin #2.5; if (f_run) fclk = ~fclk; end
  always begin #7.5; if (b_run) bclk = ~bclk; end

  core_clk_switch u_core_clk_switch (
    .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .mode(mode),
    .acc_req(acc_req), .acc_done(acc_done),
    .core_clk(core_clk), .bus_on(bus_on), .mode_err(mode_err)
  );

  // edge counters
  bit cnt_en = 1'b0;
  int nc = 0, nb = 0, nf = 0;
  always @(posedge core_clk) if (cnt_en) nc++;
  always @(posedge bclk)     if (cnt_en) nb++;
  always @(posedge fclk)     if (cnt_en) nf++;

  // pulse width monitor
  bit     mon_en = 1'b0;
  realtime last_t = 0.0;
  realtime min_w = 1000.0;
  always @(core_clk) begin
    if (mon_en && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_window(input realtime win);
    nc = 0; nb = 0; nf = 0;
    cnt_en = 1'b1;
    #(win);
    cnt_en = 1'b0;
  endtask

  task automatic bus_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge bclk);
  endtask

  task automatic follows_bus(input string tag);
    count_window(300.0);
    check((nc >= nb - 1) && (nc <= nb + 1), tag, nc, nb);
  endtask

  task automatic follows_fast(input string tag);
    count_window(300.0);
    check((nc >= nf - 1) && (nc <= nf + 1), tag, nc, nf);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode = 2'b00;
    #50;
    check(bus_on === 1'b1, "R1 bus_on during reset", bus_on, 1);
    @(negedge bclk); rst_n = 1'b1;
    bus_cycles(4);
    mon_en = 1'b1;
    check(bus_on === 1'b1, "R1 bus_on after reset", bus_on, 1);
    check(mode_err === 1'b0, "R1 mode_err after reset", mode_err, 0);
    follows_bus("R1 core follows bclk after reset");
  endtask

  task automatic t_bus_ignores_fast;
    f_run = 1'b0;
    follows_bus("R3 core follows bclk with fclk stopped");
    check(bus_on === 1'b1, "R3 bus_on with fclk stopped", bus_on, 1);
    f_run = 1'b1;
    follows_bus("R3 core follows bclk with fclk running");
  endtask

  task automatic t_sync_mode;
    @(negedge bclk); mode = 2'b01;
    bus_cycles(3);
    check(mode_err === 1'b1, "R2 mode_err on 01", mode_err, 1);
    check(bus_on === 1'b1, "R2 bus_on on 01", bus_on, 1);
    follows_bus("R2 core follows bclk on 01");
    @(negedge bclk); mode = 2'b00;
    bus_cycles(3);
    check(mode_err === 1'b0, "R2 mode_err cleared", mode_err, 0);
  endtask

  task automatic t_async_idle(input logic [1:0] m, input string tag);
    @(negedge bclk); mode = m;
    bus_cycles(6);
    check(bus_on === 1'b0, {tag, " bus_on idle"}, bus_on, 0);
    follows_fast({tag, " core follows fclk"});
  endtask

  task automatic t_access;
    int waited;
    @(negedge bclk); acc_req = 1'b1;
    @(negedge bclk); acc_req = 1'b0;
    waited = 1;
    while (bus_on !== 1'b1 && waited < 10) begin
      @(negedge bclk); waited++;
    end
    check(waited <= 5, "R6 bus_on latency", waited, 5);
    follows_bus("R6 core follows bclk during access");
    bus_cycles(10);
    check(bus_on === 1'b1, "R6 bus_on held until done", bus_on, 1);
    @(negedge bclk); acc_done = 1'b1;
    @(negedge bclk); acc_done = 1'b0;
    bus_cycles(3);
    check(bus_on === 1'b0, "R7 bus_on cleared after done", bus_on, 0);
    follows_fast("R7 core back on fclk");
  endtask

  task automatic t_stray_done;
    @(negedge bclk); acc_done = 1'b1;
    @(negedge bclk); acc_done = 1'b0;
    bus_cycles(4);
    check(bus_on === 1'b0, "R9 bus_on after stray done", bus_on, 0);
    follows_fast("R9 core on fclk after stray done");
  endtask

  task automatic t_stop_fast;
    logic lvl;
    int diff;
    #1.0; f_run = 1'b0;
    #3.0; lvl = core_clk; diff = 0;
    for (int i = 0; i < 12; i++) begin #7.0; if (core_clk !== lvl) diff++; end
    check(diff == 0, "R8 core holds with fclk stopped", diff, 0);
    f_run = 1'b1;
    #20;
  endtask

  task automatic t_stop_bus;
    logic lvl;
    int diff;
    @(negedge bclk); mode = 2'b00;
    bus_cycles(6);
    check(bus_on === 1'b1, "R1 back to bus mode", bus_on, 1);
    #2.0; b_run = 1'b0;
    #3.0; lvl = core_clk; diff = 0;
    for (int i = 0; i < 12; i++) begin #9.0; if (core_clk !== lvl) diff++; end
    check(diff == 0, "R8 core holds with bclk stopped", diff, 0);
    b_run = 1'b1;
    bus_cycles(2);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_bus_ignores_fast();
    t_sync_mode();
    t_async_idle(2'b11, "R4 mode 11");
    t_access();
    t_stray_done();
    t_stop_fast();
    t_async_idle(2'b10, "R1 mode 10");
    t_access();
    t_stop_bus();
    check(min_w >= 2.4, "R5 min core_clk phase (ps)", int'(min_w * 1000.0), 2500);
    finished = 1'b1;
    summary();
  end

  initial begin
    #200_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
    end
  end

endmodule